// File: doc/BRIEF.md
# Block-Transfer Host Register Window

This block sits between a host bus and a downstream message processor. It presents three byte-wide registers to the host: a control and status register, a data port and an interrupt mask register. A host builds a request by writing bytes into the data port. It then sets the request-attention control bit, which marks the controller busy and sends a one-cycle strobe downstream. The processor reads the request bytes through a side port. It loads its reply into the outbound buffer, then pulses a done signal. That pulse clears the busy flag and raises the reply-attention flag. The host then drains the reply by reading the data port.

The control register combines several kinds of bit in one byte. Some bits are strobes that reset a buffer pointer. Some are flags cleared by writing one, one flag toggles when written with one, and one flag the host can only read. The data port moves its pointer on every access. Reading the last byte of a reply empties the outbound buffer. A write count that runs past the buffer depth stays visible, so the processor can detect an overrun. The block does not interpret messages and does not generate interrupts. The mask register is only stored and exported.

Top module: `bt_host_window`

## Requirements
- R1: The register offset is `host_addr` ANDed with (window size − 1). A window-size parameter of 0 selects 4. Offset 0 is control, offset 1 is data, offset 2 is mask.
- R2: A read of any other offset returns 0xFF. A write to any other offset changes no register.
- R3: Writing control bit 0 as 1 sets the inbound count to zero. Writing control bit 1 as 1 sets the outbound read pointer to zero without changing the outbound length.
- R4: Control bit 3 (reply attention) and bit 4 (software attention) clear when written with 1. Writing 0 to them has no effect. The host cannot change bit 7 (controller busy).
- R5: Writing control bit 6 (host busy) as 1 inverts it.
- R6: Writing control bit 2 as 1 sets bit 7. In the cycle after that write, `req_ready` is high for exactly one cycle.
- R7: A data write stores the byte at index `req_len` only when `req_len` is below DEPTH. `req_len` counts every data write and saturates at 2^CNT_W−1, which is at least DEPTH+1. `req_rd_byte` returns the stored byte at `req_rd_idx`.
- R8: While the read pointer is below the outbound length, a data read returns the byte at the pointer and advances it. Reading the last byte clears both pointer and length. Otherwise a data read returns 0xFF.
- R9: A `rsp_done` pulse loads the outbound length as min(`rsp_len`, DEPTH), zeroes the read pointer, clears bit 7 and sets bit 3. Bytes reach the outbound buffer through `rsp_wr_en`.
- R10: A `sw_atn_set` pulse sets control bit 4. A set event wins over a same-cycle host clear.
- R11: Mask bits [1:0] are written and read back through offset 2 and drive `irq_cfg`. Mask bits [7:2] read as 0.
- R12: After reset, control reads 0x00, mask reads 0x00 and a data read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Host access strobe, one byte per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid in the cycle of a read access |
| req_ready | output | 1 | One-cycle strobe: request complete |
| req_len | output | CNT_W | Inbound write count |
| req_rd_idx | input | IDX_W | Inbound buffer index for the processor |
| req_rd_byte | output | 8 | Inbound byte at `req_rd_idx` |
| rsp_wr_en | input | 1 | Outbound byte write enable |
| rsp_wr_idx | input | IDX_W | Outbound byte index |
| rsp_wr_byte | input | 8 | Outbound byte |
| rsp_len | input | CNT_W | Reply length taken on `rsp_done` |
| rsp_done | input | 1 | Reply loaded pulse |
| sw_atn_set | input | 1 | Pulse setting software attention |
| irq_cfg | output | 2 | Stored mask bits [1:0] |

## Verification
A wrong busy or attention flag appears in the next control read and in the `req_ready` strobe one cycle after the attention write. A broken outbound pointer or length shows up on the very next data-port read. It returns a byte out of order, or 0xFF where a byte was due, or a byte after the reply has ended. A faulty inbound count shows at once on `req_len` and `req_rd_byte`, including past the buffer depth, where saturation and the write guard are both exercised.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_DATA = 2'd1,
      REG_MASK = 2'd2,
      REG_NONE = 2'd3
   } bt_reg_e;

   localparam int unsigned CB_CLR_IN  = 0;
   localparam int unsigned CB_CLR_OUT = 1;
   localparam int unsigned CB_H2C     = 2;
   localparam int unsigned CB_C2H     = 3;
   localparam int unsigned CB_SWATN   = 4;
   localparam int unsigned CB_HBUSY   = 6;
   localparam int unsigned CB_CBUSY   = 7;

   localparam logic [7:0] EMPTY_BYTE = 8'hFF;
endpackage

// File: rtl/bt_ctrl_bits.sv
module bt_ctrl_bits
   import bt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       evt_done,
   input  logic       evt_swatn,
   output logic [7:0] ctrl_byte,
   output logic       clr_in,
   output logic       clr_out,
   output logic       req_pulse
);
   logic c2h_q, swatn_q, hbusy_q, cbusy_q, req_q;
   logic h2c_wr;
   logic unused_bits;

   assign unused_bits = ^{wdata[5]};
   assign h2c_wr  = wr_en & wdata[CB_H2C];
   assign clr_in  = wr_en & wdata[CB_CLR_IN];
   assign clr_out = wr_en & wdata[CB_CLR_OUT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c2h_q   <= 1'b0;
         swatn_q <= 1'b0;
         hbusy_q <= 1'b0;
         cbusy_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         // set events take precedence over host clears
         if (evt_done)                       c2h_q <= 1'b1;
         else if (wr_en && wdata[CB_C2H])    c2h_q <= 1'b0;

         if (evt_swatn)                      swatn_q <= 1'b1;
         else if (wr_en && wdata[CB_SWATN])  swatn_q <= 1'b0;

         if (wr_en && wdata[CB_HBUSY])       hbusy_q <= ~hbusy_q;

         if (h2c_wr)                         cbusy_q <= 1'b1;
         else if (evt_done)                  cbusy_q <= 1'b0;

         req_q <= h2c_wr;
      end
   end

   always_comb begin
      ctrl_byte            = 8'h00;
      ctrl_byte[CB_C2H]    = c2h_q;
      ctrl_byte[CB_SWATN]  = swatn_q;
      ctrl_byte[CB_HBUSY]  = hbusy_q;
      ctrl_byte[CB_CBUSY]  = cbusy_q;
   end

   assign req_pulse = req_q;
endmodule

// File: rtl/bt_in_buf.sv
module bt_in_buf #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_byte,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0]      cnt_q;
   logic [DEPTH-1:0][7:0] cells;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (clr)                       cnt_q <= '0;
      else if (wr_en && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      logic [7:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   cell_q <= '0;
         else if (wr_en && !clr && cnt_q == CNT_W'(gi)) cell_q <= wr_byte;
      end
      assign cells[gi] = cell_q;
   end

   always_comb begin
      rd_byte = 8'h00;
      if (32'(rd_idx) < DEPTH) rd_byte = cells[rd_idx];
   end

   assign count = cnt_q;
endmodule

// File: rtl/bt_out_buf.sv
module bt_out_buf
   import bt_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_ptr,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [7:0]       ld_byte,
   input  logic             done,
   input  logic [CNT_W-1:0] done_len,
   input  logic             rd_en,
   output logic [7:0]       rd_byte,
   output logic [CNT_W-1:0] ptr,
   output logic [CNT_W-1:0] len
);
   localparam logic [CNT_W-1:0] LEN_CAP = CNT_W'(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [CNT_W-1:0] ptr_q, len_q, len_clamped;
   logic             have_byte;

   assign have_byte   = ptr_q < len_q;
   assign len_clamped = (done_len > LEN_CAP) ? LEN_CAP : done_len;

   always_ff @(posedge clk) begin
      if (ld_en && 32'(ld_idx) < DEPTH) mem[ld_idx] <= ld_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         len_q <= '0;
      end else if (done) begin
         ptr_q <= '0;
         len_q <= len_clamped;
      end else if (clr_ptr) begin
         ptr_q <= '0;
      end else if (rd_en && have_byte) begin
         if (ptr_q + 1'b1 == len_q) begin
            ptr_q <= '0;
            len_q <= '0;
         end else begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   assign rd_byte = have_byte ? mem[ptr_q[IDX_W-1:0]] : EMPTY_BYTE;
   assign ptr     = ptr_q;
   assign len     = len_q;
endmodule

// File: rtl/bt_host_window.sv
module bt_host_window
   import bt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned WIN_SIZE = 0,
   parameter int unsigned DEPTH    = 64,
   localparam int unsigned IDX_W   = $clog2(DEPTH),
   localparam int unsigned CNT_W   = $clog2(DEPTH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_en,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              req_ready,
   output logic [CNT_W-1:0]  req_len,
   input  logic [IDX_W-1:0]  req_rd_idx,
   output logic [7:0]        req_rd_byte,
   input  logic              rsp_wr_en,
   input  logic [IDX_W-1:0]  rsp_wr_idx,
   input  logic [7:0]        rsp_wr_byte,
   input  logic [CNT_W-1:0]  rsp_len,
   input  logic              rsp_done,
   input  logic              sw_atn_set,
   output logic [1:0]        irq_cfg
);
   localparam int unsigned WIN_EFF = (WIN_SIZE == 0) ? 4 : WIN_SIZE;
   localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(WIN_EFF - 1);

   if ((WIN_EFF & (WIN_EFF - 1)) != 0 || WIN_EFF < 4) begin : g_bad_win
      $error("bt_host_window: window size must be a power of two of at least 4");
   end
   if (DEPTH < 4 || DEPTH > 255) begin : g_bad_depth
      $error("bt_host_window: DEPTH must lie in 4..255");
   end
   if (ADDR_W < $clog2(WIN_EFF)) begin : g_bad_addr
      $error("bt_host_window: ADDR_W too narrow for the window");
   end

   logic [ADDR_W-1:0] reg_off;
   bt_reg_e           reg_sel;
   logic              ctrl_wr, data_wr, data_rd, mask_wr;
   logic [7:0]        ctrl_byte, out_rd_byte;
   logic              clr_in, clr_out;
   logic [1:0]        mask_q;
   logic [CNT_W-1:0]  in_cnt, out_ptr, out_len;
   logic              unused_wdata;

   assign unused_wdata = ^{host_wdata[7:2]};
   assign reg_off = host_addr & OFF_MASK;

   always_comb begin
      case (reg_off)
         ADDR_W'(0): reg_sel = REG_CTRL;
         ADDR_W'(1): reg_sel = REG_DATA;
         ADDR_W'(2): reg_sel = REG_MASK;
         default:    reg_sel = REG_NONE;
      endcase
   end

   assign ctrl_wr = host_en &  host_we & (reg_sel == REG_CTRL);
   assign data_wr = host_en &  host_we & (reg_sel == REG_DATA);
   assign data_rd = host_en & ~host_we & (reg_sel == REG_DATA);
   assign mask_wr = host_en &  host_we & (reg_sel == REG_MASK);

   bt_ctrl_bits u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_wr),
      .wdata     (host_wdata),
      .evt_done  (rsp_done),
      .evt_swatn (sw_atn_set),
      .ctrl_byte (ctrl_byte),
      .clr_in    (clr_in),
      .clr_out   (clr_out),
      .req_pulse (req_ready)
   );

   bt_in_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_in),
      .wr_en   (data_wr),
      .wr_byte (host_wdata),
      .rd_idx  (req_rd_idx),
      .rd_byte (req_rd_byte),
      .count   (in_cnt)
   );

   bt_out_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_ptr  (clr_out),
      .ld_en    (rsp_wr_en),
      .ld_idx   (rsp_wr_idx),
      .ld_byte  (rsp_wr_byte),
      .done     (rsp_done),
      .done_len (rsp_len),
      .rd_en    (data_rd),
      .rd_byte  (out_rd_byte),
      .ptr      (out_ptr),
      .len      (out_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= 2'b00;
      else if (mask_wr) mask_q <= host_wdata[1:0];
   end

   always_comb begin
      unique case (reg_sel)
         REG_CTRL: host_rdata = ctrl_byte;
         REG_DATA: host_rdata = out_rd_byte;
         REG_MASK: host_rdata = {6'b000000, mask_q};
         default:  host_rdata = EMPTY_BYTE;
      endcase
   end

   assign req_len = in_cnt;
   assign irq_cfg = mask_q;
endmodule

// File: rtl/bt_host_window_chk.sv
module bt_host_window_chk
   import bt_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_en,
   input logic             host_we,
   input logic [7:0]       host_wdata,
   input logic [7:0]       host_rdata,
   input bt_reg_e          reg_sel,
   input logic [7:0]       ctrl_q,
   input logic             req_ready,
   input logic             rsp_done,
   input logic [CNT_W-1:0] in_cnt,
   input logic [CNT_W-1:0] out_ptr,
   input logic [CNT_W-1:0] out_len
);
   logic h2c_wr, dat_wr, clr_wr;
   assign h2c_wr = host_en && host_we && reg_sel == REG_CTRL && host_wdata[CB_H2C];
   assign clr_wr = host_en && host_we && reg_sel == REG_CTRL && host_wdata[CB_CLR_IN];
   assign dat_wr = host_en && host_we && reg_sel == REG_DATA;

   p_unmapped_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && !host_we && reg_sel == REG_NONE) |-> host_rdata == 8'hFF);

   p_cbusy_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_done && !h2c_wr) |=> $stable(ctrl_q[CB_CBUSY]));

   p_req_follows_atn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      h2c_wr |=> (req_ready && ctrl_q[CB_CBUSY]));

   p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !h2c_wr) |=> !req_ready);

   p_in_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !clr_wr && in_cnt != {CNT_W{1'b1}}) |=> in_cnt == $past(in_cnt) + 1'b1);

   p_out_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ptr < out_len) || (out_ptr == '0 && out_len == '0));

   p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !h2c_wr) |=> (!ctrl_q[CB_CBUSY] && ctrl_q[CB_C2H]));

   p_out_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(out_len) <= DEPTH);
endmodule

bind bt_host_window bt_host_window_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_en    (host_en),
   .host_we    (host_we),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .reg_sel    (reg_sel),
   .ctrl_q     (ctrl_byte),
   .req_ready  (req_ready),
   .rsp_done   (rsp_done),
   .in_cnt     (in_cnt),
   .out_ptr    (out_ptr),
   .out_len    (out_len)
);

// File: tb/test_bt_host_window.sv
`timescale 1ns/1ps
module test_bt_host_window;
   localparam int DEPTH = 64;
   localparam int IDX_W = 6;
   localparam int CNT_W = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             host_en = 1'b0, host_we = 1'b0;
   logic [7:0]       host_addr = '0, host_wdata = '0;
   logic [7:0]       host_rdata;
   logic             req_ready;
   logic [CNT_W-1:0] req_len;
   logic [IDX_W-1:0] req_rd_idx = '0;
   logic [7:0]       req_rd_byte;
   logic             rsp_wr_en = 1'b0;
   logic [IDX_W-1:0] rsp_wr_idx = '0;
   logic [7:0]       rsp_wr_byte = '0;
   logic [CNT_W-1:0] rsp_len = '0;
   logic             rsp_done = 1'b0, sw_atn_set = 1'b0;
   logic [1:0]       irq_cfg;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   bt_host_window #(.ADDR_W(8), .WIN_SIZE(0), .DEPTH(DEPTH)) i_bt_host_window (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .req_ready(req_ready), .req_len(req_len), .req_rd_idx(req_rd_idx),
      .req_rd_byte(req_rd_byte), .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx),
      .rsp_wr_byte(rsp_wr_byte), .rsp_len(rsp_len), .rsp_done(rsp_done),
      .sw_atn_set(sw_atn_set), .irq_cfg(irq_cfg));

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_en = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b0; host_addr = a;
      #5 d = host_rdata;
      @(negedge clk);
      host_en = 1'b0;
   endtask

   task automatic load_rsp(input int n, input int base, input int len);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rsp_wr_en = 1'b1; rsp_wr_idx = IDX_W'(i); rsp_wr_byte = 8'(base + i);
      end
      @(negedge clk);
      rsp_wr_en = 1'b0; rsp_len = CNT_W'(len); rsp_done = 1'b1;
      @(negedge clk);
      rsp_done = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      host_rd(8'h00, d); check("R12 control after reset", d, 8'h00);
      host_rd(8'h02, d); check("R12 mask after reset", d, 8'h00);
      host_rd(8'h01, d); check("R12 data read empty", d, 8'hFF);
   endtask

   task automatic t_decode;
      logic [7:0] d;
      host_wr(8'h06, 8'h03);             // alias of offset 2
      host_rd(8'h02, d); check("R1 mask via alias", d, 8'h03);
      check("R11 irq_cfg", irq_cfg, 2'b11);
      host_wr(8'h02, 8'hFC);
      host_rd(8'h02, d); check("R11 upper mask bits read 0", d, 8'h00);
      host_wr(8'h03, 8'hFF);             // unmapped
      host_rd(8'h00, d); check("R2 unmapped write leaves control", d, 8'h00);
      host_rd(8'h02, d); check("R2 unmapped write leaves mask", d, 8'h00);
      check("R2 unmapped write leaves count", req_len, 0);
      host_rd(8'h07, d); check("R2 unmapped read", d, 8'hFF);
   endtask

   task automatic t_request;
      logic [7:0] d;
      host_wr(8'h01, 8'h11);
      host_wr(8'h05, 8'h12);             // alias of data
      host_wr(8'h01, 8'h13);
      host_wr(8'h01, 8'h14);
      check("R7 count after four writes", req_len, 4);
      req_rd_idx = 6'd1; #1 check("R1 R7 byte via alias", req_rd_byte, 8'h12);
      req_rd_idx = 6'd3; #1 check("R7 byte 3", req_rd_byte, 8'h14);
      check("R6 no strobe before attention", req_ready, 0);
      host_wr(8'h00, 8'h04);
      check("R6 strobe after attention write", req_ready, 1);
      @(negedge clk); check("R6 strobe lasts one cycle", req_ready, 0);
      host_rd(8'h00, d); check("R6 controller busy set", d, 8'h80);
      host_wr(8'h00, 8'h80);
      host_rd(8'h00, d); check("R4 busy is read only", d, 8'h80);
      host_wr(8'h00, 8'h01);
      check("R3 inbound count cleared", req_len, 0);
   endtask

   task automatic t_toggle;
      logic [7:0] d;
      host_wr(8'h00, 8'h40);
      host_rd(8'h00, d); check("R5 host busy toggled on", d, 8'hC0);
      host_wr(8'h00, 8'h40);
      host_rd(8'h00, d); check("R5 host busy toggled off", d, 8'h80);
   endtask

   task automatic t_response;
      logic [7:0] d;
      load_rsp(3, 8'hA0, 3);
      host_rd(8'h00, d); check("R9 busy cleared attention set", d, 8'h08);
      host_wr(8'h00, 8'h00);
      host_rd(8'h00, d); check("R4 write 0 keeps attention", d, 8'h08);
      host_wr(8'h00, 8'h08);
      host_rd(8'h00, d); check("R4 attention cleared by 1", d, 8'h00);
      host_rd(8'h01, d); check("R8 byte 0", d, 8'hA0);
      host_rd(8'h01, d); check("R8 byte 1", d, 8'hA1);
      host_wr(8'h00, 8'h02);
      host_rd(8'h01, d); check("R3 read pointer rewound", d, 8'hA0);
      host_rd(8'h01, d); check("R8 byte 1 again", d, 8'hA1);
      host_rd(8'h01, d); check("R8 last byte", d, 8'hA2);
      host_rd(8'h01, d); check("R8 past end", d, 8'hFF);
      host_wr(8'h00, 8'h02);
      host_rd(8'h01, d); check("R8 length cleared at end", d, 8'hFF);
   endtask

   task automatic t_swatn;
      logic [7:0] d;
      @(negedge clk); sw_atn_set = 1'b1; @(negedge clk); sw_atn_set = 1'b0;
      host_rd(8'h00, d); check("R10 software attention set", d, 8'h10);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b1; host_addr = 8'h00; host_wdata = 8'h10;
      sw_atn_set = 1'b1;
      @(negedge clk);
      host_en = 1'b0; host_we = 1'b0; sw_atn_set = 1'b0;
      host_rd(8'h00, d); check("R10 set wins over clear", d, 8'h10);
      host_wr(8'h00, 8'h10);
      host_rd(8'h00, d); check("R4 software attention cleared", d, 8'h00);
   endtask

   task automatic t_overrun;
      host_wr(8'h00, 8'h01);
      for (int i = 0; i < 70; i++) host_wr(8'h01, 8'(i));
      check("R7 count past depth", req_len, 70);
      req_rd_idx = 6'd63; #1 check("R7 last cell holds in-range byte", req_rd_byte, 63);
      for (int i = 0; i < 60; i++) host_wr(8'h01, 8'hEE);
      check("R7 count saturates", req_len, 127);
      req_rd_idx = 6'd63; #1 check("R7 overrun did not overwrite", req_rd_byte, 63);
   endtask

   task automatic t_clamp;
      logic [7:0] d;
      load_rsp(DEPTH, 8'h00, 100);
      for (int i = 0; i < DEPTH; i++) begin
         host_rd(8'h01, d);
         if (i == 0 || i == DEPTH - 1) check("R9 clamped reply byte", d, i);
      end
      host_rd(8'h01, d); check("R9 length clamped to depth", d, 8'hFF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_decode();
      t_request();
      t_toggle();
      t_response();
      t_swatn();
      t_overrun();
      t_clamp();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule